// File: doc/BRIEF.md
# Four-Slot Shift-Chain Queue

This block is a small first-in first-out queue whose storage is a chain of data registers that all move at once. A new word always lands in the first stage (the tail) and every older word moves one stage deeper on the same clock edge. There are no read or write pointers. A Mealy controller tracks how many words are held. A multiplexer picks the oldest word from the stage whose index matches the fill count minus one. Removing a word changes no storage at all. It only lowers the fill count, so the multiplexer then picks the stage one position nearer the tail.

Requests arrive on two plain strobes, one to add a word and one to remove the head. There is no ready signal and no back-pressure. A request that cannot be served is refused. It raises a one-cycle error pulse, and the queue keeps its fill count and contents. The refused cases are an add while full, a remove while empty, and an add and a remove in the same cycle. The producer and consumer are expected to watch the full and empty flags. The head word appears on the output combinationally from the stored stages. It is meaningful only while the queue is not empty.

Top module: `sr_fifo`

## Requirements
- R1: While the active-low synchronous reset is applied and after it is released, the fill level is 0, empty_o is 1, full_o is 0 and err_o is 0.
- R2: An add request (wr_i=1, del_i=0) while the level is below 4 increases level_o by one after the next clock edge. The word on din_i becomes the newest entry.
- R3: When the level is nonzero, dout_o shows the oldest word still held, so words leave in the order they were added.
- R4: A remove request (del_i=1, wr_i=0) while the level is above 0 lowers level_o by one after the next clock edge. The remaining words keep their values and order.
- R5: An add request while the level is 4 is refused. The level stays 4 and the held words are unchanged.
- R6: A remove request while the level is 0 is refused, and the level stays 0.
- R7: A cycle with wr_i=1 and del_i=1 is refused at any level. The level and all held words are unchanged.
- R8: err_o is 1 in exactly the cycle after each refused request (R5, R6, R7) and 0 after every other cycle.
- R9: empty_o is 1 exactly when the level is 0, and full_o is 1 exactly when the level is 4.
- R10: level_o is the binary count of held words, 3'b000 to 3'b100, and never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Add-word strobe |
| del_i | input | 1 | Remove-head strobe |
| din_i | input | DATA_W | Word to add |
| dout_o | output | DATA_W | Oldest held word (head) |
| err_o | output | 1 | One-cycle pulse after a refused request |
| empty_o | output | 1 | No word held |
| full_o | output | 1 | Four words held |
| level_o | output | 3 | Number of words held |

## Verification
The bench first runs directed sequences. It fills the queue with distinct words and then adds once more while full. It drains the queue and then removes once more while empty. It issues simultaneous add and remove at empty, partial and full levels. These separate the three refusal causes from each other and from legal moves. A seeded random phase follows, with biased mixes of add, remove, both and idle. It walks the level up and down many times, so ordering faults are exposed at every head-select position. Each cycle is compared against a reference queue kept in the bench. This catches a wrong stage choice, a shift on remove, or a change of state on a refused cycle.

// File: rtl/sr_fifo_pkg.sv
package sr_fifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_FAULT = 2'd3
  } fifo_op_e;

  // Sort one cycle's request into the action the controller takes.
  function automatic fifo_op_e classify(input logic wr, input logic del,
                                        input logic is_empty, input logic is_full);
    fifo_op_e op;
    if (wr && del)                op = OP_FAULT;
    else if (wr && is_full)       op = OP_FAULT;
    else if (del && is_empty)     op = OP_FAULT;
    else if (wr)                  op = OP_PUSH;
    else if (del)                 op = OP_POP;
    else                          op = OP_IDLE;
    return op;
  endfunction

endpackage

// File: rtl/sr_fifo_ctrl.sv
module sr_fifo_ctrl
  import sr_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          del_i,
  output logic          shift_en_o,
  output logic [SW-1:0] sel_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          err_o
);

  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

  logic [LW-1:0] level_q;
  logic [LW-1:0] level_m1;
  logic          err_q;
  fifo_op_e      op;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LVL_FULL);
  assign op      = classify(wr_i, del_i, empty_o, full_o);

  // Mealy output: the chain moves only on an accepted add.
  assign shift_en_o = (op == OP_PUSH);

  assign level_m1 = level_q - LW'(1);
  assign sel_o    = empty_o ? '0 : level_m1[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (op == OP_FAULT);
      unique case (op)
        OP_PUSH: level_q <= level_q + LW'(1);
        OP_POP:  level_q <= level_m1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign level_o = level_q;
  assign err_o   = err_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_FULL); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o)); // R9
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !del_i && !full_o) |=> (level_q == $past(level_q) + LW'(1))); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (del_i && !wr_i && !empty_o) |=> (level_q == $past(level_q) - LW'(1))); // R4
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_o) |=> (err_o && $stable(level_q))); // R5
  AST_EMPTY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (del_i && empty_o) |=> (err_o && $stable(level_q))); // R6
  AST_BOTH_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && del_i) |=> (err_o && $stable(level_q))); // R7
  AST_ERR_ONLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !del_i) |=> !err_o); // R8

endmodule

// File: rtl/sr_fifo_chain.sv
module sr_fifo_chain #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int FLAT_W = DATA_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [FLAT_W-1:0] stages_o
);

  logic [DATA_W-1:0] stage_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    logic [DATA_W-1:0] src;
    if (gi == 0) begin : g_tail
      assign src = din_i;
    end else begin : g_deep
      assign src = stage_q[gi-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          stage_q[gi] <= '0;
      else if (shift_en_i) stage_q[gi] <= src;
    end

    assign stages_o[gi*DATA_W +: DATA_W] = stage_q[gi];
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(stages_o)); // R4
  AST_TAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> (stages_o[DATA_W-1:0] == $past(din_i))); // R2

endmodule

// File: rtl/sr_fifo_headmux.sv
module sr_fifo_headmux #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int FLAT_W = DATA_W * DEPTH,
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [FLAT_W-1:0] stages_i,
  input  logic [SW-1:0]     sel_i,
  output logic [DATA_W-1:0] head_o
);

  always_comb begin
    head_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (sel_i == SW'(k)) head_o = stages_i[k*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/sr_fifo.sv
module sr_fifo #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              del_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              err_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [2:0]        level_o
);

  localparam int DEPTH  = 4;
  localparam int FLAT_W = DATA_W * DEPTH;
  localparam int SW     = $clog2(DEPTH);

  logic              shift_en;
  logic [SW-1:0]     sel;
  logic [FLAT_W-1:0] stages;

  sr_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_i),
    .del_i      (del_i),
    .shift_en_o (shift_en),
    .sel_o      (sel),
    .level_o    (level_o),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .err_o      (err_o)
  );

  sr_fifo_chain #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (shift_en),
    .din_i      (din_i),
    .stages_o   (stages)
  );

  sr_fifo_headmux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mux (
    .stages_i (stages),
    .sel_i    (sel),
    .head_o   (dout_o)
  );

  AST_ERR_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(stages)); // R7

endmodule

// File: tb/tb_sr_fifo.sv
module tb_sr_fifo;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_i, del_i;
  logic [W-1:0] din_i;
  logic [W-1:0] dout_o;
  logic         err_o, empty_o, full_o;
  logic [2:0]   level_o;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mq [4];
  int           mcnt = 0;
  logic         exp_err = 1'b0;

  always #10 clk = ~clk;

  sr_fifo #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .del_i(del_i), .din_i(din_i),
    .dout_o(dout_o), .err_o(err_o), .empty_o(empty_o), .full_o(full_o),
    .level_o(level_o)
  );

  function automatic logic refused(input logic wr, input logic del, input int cnt);
    return (wr && del) || (wr && cnt == 4) || (del && cnt == 0);
  endfunction

  task automatic chk(input string tag, input logic ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_all(input string lvl_tag);
    chk(lvl_tag, level_o == 3'(mcnt), int'(level_o), mcnt);
    chk("R10", level_o <= 3'd4, int'(level_o), 4);
    chk("R9", empty_o == (mcnt == 0), int'(empty_o), int'(mcnt == 0));
    chk("R9", full_o == (mcnt == 4), int'(full_o), int'(mcnt == 4));
    chk("R8", err_o == exp_err, int'(err_o), int'(exp_err));
    if (mcnt > 0) chk("R3", dout_o == mq[0], int'(dout_o), int'(mq[0]));
  endtask

  // Drive one cycle of request at a falling edge, then check at the next falling edge.
  task automatic step(input logic wr, input logic del, input logic [W-1:0] d);
    string tag;
    wr_i = wr; del_i = del; din_i = d;
    exp_err = refused(wr, del, mcnt);
    if (exp_err) begin
      if (wr && del)   tag = "R7";
      else if (wr)     tag = "R5";
      else             tag = "R6";
    end else if (wr) begin
      mq[mcnt] = d; mcnt++; tag = "R2";
    end else if (del) begin
      for (int k = 0; k < 3; k++) mq[k] = mq[k+1];
      mcnt--; tag = "R4";
    end else tag = "R10";
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    rst_n = 1'b0; wr_i = 1'b0; del_i = 1'b0; din_i = '0;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk("R1", level_o == 3'd0 && empty_o && !full_o && !err_o, int'(level_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", level_o == 3'd0 && empty_o && !full_o && !err_o, int'(level_o), 0);

    // R6: remove from empty
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    // R7 at empty
    step(1'b1, 1'b1, 8'hEE);
    // R2/R3 fill with distinct words
    step(1'b1, 1'b0, 8'hA1);
    step(1'b1, 1'b0, 8'hB2);
    // R7 at partial level
    step(1'b1, 1'b1, 8'h77);
    step(1'b1, 1'b0, 8'hC3);
    step(1'b1, 1'b0, 8'hD4);
    // R5: add while full, twice back to back
    step(1'b1, 1'b0, 8'h55);
    step(1'b1, 1'b0, 8'h66);
    // R7 at full
    step(1'b1, 1'b1, 8'h99);
    step(1'b0, 1'b0, 8'h00);
    // R4: drain fully, then one extra remove (R6)
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b0, 8'h00);

    // Random phase with shifting bias
    for (int i = 0; i < 3000; i++) begin
      int bias;
      bias = (i / 250) % 3;
      r = int'($urandom_range(99));
      if (r < 8)                                step(1'b1, 1'b1, 8'($urandom));
      else if (r < 20)                          step(1'b0, 1'b0, 8'($urandom));
      else if ((bias == 0 && r < 70) ||
               (bias == 1 && r < 40) ||
               (bias == 2 && r < 55))           step(1'b1, 1'b0, 8'($urandom));
      else                                      step(1'b0, 1'b1, 8'($urandom));
    end

    // R1: reset mid-run returns to empty
    rst_n = 1'b0; wr_i = 1'b0; del_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mcnt = 0; exp_err = 1'b0;
    @(negedge clk);
    chk("R1", level_o == 3'd0 && empty_o && !err_o, int'(level_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule